// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a single first-in first-out buffer channel. It has a write port and a read port, and each port runs on its own clock. The two clocks may be one and the same net, or they may be fully unrelated. Words are 9 bits wide by default. The depth is a power of two set by parameter, 256 words by default, and 512, 1024, 2048 and 4096 are also valid. Every control input and every status flag is active low.

A write needs two write qualifiers and a read needs two read qualifiers. The second write qualifier can take a second role. Its level while reset is held picks the mode:
- **Enable mode:** the pin acts as an ordinary second qualifier.
- **Load mode:** the pin acts as a load strobe. Each load edge stores one threshold, taken from the low bits of the write data. The almost-empty threshold is stored first and the almost-full threshold second.

The buffer reports empty and full. It also reports almost-empty and almost-full against those two thresholds. An output-enable input releases the read data. Instead of real high impedance, this is modelled as a drive indicator with forced-zero data.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: In enable mode, a word is stored on a rising `wr_clk` edge when `wr_en1_n` and `wr_en2_ld_n` are both low. Words leave in write order, and `rd_data` takes the next word on the `rd_clk` edge of an accepted read.
- R2: A read happens only when `rd_en1_n` and `rd_en2_n` are both low at a rising `rd_clk` edge. With either one high, `rd_data` and the stored contents are unchanged.
- R3: In enable mode, a write with only one of the two write qualifiers low is ignored.
- R4: While `full_n` is low, write attempts are ignored. The buffer holds exactly DEPTH words, and those words are later read out unchanged and in order.
- R5: While `empty_n` is low, read attempts are ignored and `rd_data` keeps its last value.
- R6: When `out_en_n` is high, `rd_drive` is 0 and `rd_data` is all zeros. When `out_en_n` is low, `rd_drive` is 1 and `rd_data` shows the last word read.
- R7: `empty_n` is low exactly when the read side sees 0 words. `full_n` is low exactly when the write side sees DEPTH words.
  - Each flag updates at the same edge as its own side's operation.
  - A change made by the opposite side shows within four cycles of the flag's own clock.
- R8: `almost_empty_n` is low when the count is at most the almost-empty threshold. `almost_full_n` is low when the count is at least DEPTH minus the almost-full threshold.
- R9: Reset is synchronous and active high, and it clears both pointers. Right after reset, `empty_n` and `almost_empty_n` are 0, `full_n` and `almost_full_n` are 1, and both thresholds are 7.
- R10: Load mode is chosen when `wr_en2_ld_n` is low on the last reset edge of `wr_clk`. In load mode, a data write needs `wr_en1_n` low with `wr_en2_ld_n` high.
- R11: In load mode, an edge with `wr_en1_n` and `wr_en2_ld_n` both low stores the low log2(DEPTH) bits of `wr_data` into a threshold and not into memory.
  - The thresholds alternate: almost-empty first, then almost-full.
  - The order starts at almost-empty after every reset.
- R12: Each pointer crosses to the other clock domain as a Gray code that changes by at most one bit per cycle.
- R13: Data order and all four flags behave the same when the read clock is asynchronous to the write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock, same net or unrelated |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| wr_en1_n | input | 1 | First write qualifier, active low |
| wr_en2_ld_n | input | 1 | Second write qualifier, or threshold-load strobe in load mode |
| wr_data | input | DATA_W | Write word, or threshold value during a load |
| rd_en1_n | input | 1 | First read qualifier, active low |
| rd_en2_n | input | 1 | Second read qualifier, active low |
| out_en_n | input | 1 | Output enable, active low |
| rd_data | output | DATA_W | Read word, all zeros while released |
| rd_drive | output | 1 | High while read data is driven |
| empty_n | output | 1 | Low when empty |
| almost_empty_n | output | 1 | Low at or below the almost-empty threshold |
| full_n | output | 1 | Low when full |
| almost_full_n | output | 1 | Low at or above DEPTH minus the almost-full threshold |

## Verification
A wrong pointer or a bad Gray conversion shows as a flag that disagrees with the bench's arithmetic count. This disagreement appears within a few cycles of the operation that caused it. It also shows as a data word out of order on the next read.

A threshold register that was corrupted, or loaded in the wrong order, moves an almost flag to the wrong fill level. The bench sweeps the fill level one word at a time, from empty to full and back, so such a shift is caught at the first level where it matters.

A lost overflow or underflow guard surfaces at the end of the drain, as an extra word or a stale word.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  // Threshold reset value after every reset.
  localparam int DEFAULT_OFFSET = 7;

  // Which threshold register the next load stores into.
  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } ofs_sel_t;

endpackage

// File: rtl/afifo_sync.sv
// Two-flop synchronizer for Gray pointers and quasi-static values.
module afifo_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/afifo_mem.sv
// Simple dual-port storage, written so that block RAM can be inferred.
module afifo_mem #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= ram[raddr];
  end

endmodule

// File: rtl/afifo_wr_side.sv
// Write domain: qualifiers, load mode, thresholds, write pointer, full flags.
module afifo_wr_side
  import afifo_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int ADDR_W  = 8,
  parameter int DEF_OFS = DEFAULT_OFFSET
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en1_n,
  input  logic              en2_ld_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [ADDR_W:0]   wgray,
  output logic              full_n,
  output logic              af_n,
  output logic [ADDR_W-1:0] ae_ofs,
  output logic              ld_mode
);

  localparam int              PW      = ADDR_W + 1;
  localparam int              LDW     = (ADDR_W < DATA_W) ? ADDR_W : DATA_W;
  localparam logic [PW-1:0]   DEPTH_P = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [ADDR_W-1:0] OFS_RST = ADDR_W'(DEF_OFS);

  logic [PW-1:0]     wbin, wnext, rbin, wcnt, af_thr;
  logic [ADDR_W-1:0] af_ofs, ld_val;
  ofs_sel_t          sel;
  logic              wr_req, ofs_wr;

  // Threshold value: low bits of the write word, zero extended.
  always_comb begin
    ld_val = '0;
    for (int i = 0; i < LDW; i++) ld_val[i] = wdata[i];
  end

  // Read pointer back to binary in this domain.
  always_comb begin
    for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_sync >> i);
  end

  always_comb begin
    wr_req    = !en1_n && (ld_mode ? en2_ld_n : !en2_ld_n);
    ofs_wr    = ld_mode && !en1_n && !en2_ld_n;
    mem_we    = wr_req && full_n;
    mem_waddr = wbin[ADDR_W-1:0];
    wnext     = wbin + PW'(mem_we);
    wcnt      = wnext - rbin;
    af_thr    = DEPTH_P - PW'(af_ofs);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_mode <= !en2_ld_n;
      wbin    <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      af_n    <= 1'b1;
      ae_ofs  <= OFS_RST;
      af_ofs  <= OFS_RST;
      sel     <= SEL_AE;
    end else begin
      wbin   <= wnext;
      wgray  <= wnext ^ (wnext >> 1);
      full_n <= (wcnt != DEPTH_P);
      af_n   <= !(wcnt >= af_thr);
      if (ofs_wr) begin
        if (sel == SEL_AE) ae_ofs <= ld_val;
        else               af_ofs <= ld_val;
        sel <= (sel == SEL_AE) ? SEL_AF : SEL_AE;
      end
    end
  end

endmodule

// File: rtl/afifo_rd_side.sv
// Read domain: qualifiers, read pointer, empty flags.
module afifo_rd_side #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en1_n,
  input  logic              en2_n,
  input  logic [ADDR_W:0]   wgray_sync,
  input  logic [ADDR_W-1:0] ae_ofs_sync,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [ADDR_W:0]   rgray,
  output logic              empty_n,
  output logic              ae_n
);

  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] rbin, rnext, wbin, rcnt;
  logic          rd_req;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_sync >> i);
  end

  always_comb begin
    rd_req    = !en1_n && !en2_n;
    mem_re    = rd_req && empty_n;
    mem_raddr = rbin[ADDR_W-1:0];
    rnext     = rbin + PW'(mem_re);
    rcnt      = wbin - rnext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_n <= 1'b0;
      ae_n    <= 1'b0;
    end else begin
      rbin    <= rnext;
      rgray   <= rnext ^ (rnext >> 1);
      empty_n <= (rcnt != '0);
      ae_n    <= !(rcnt <= PW'(ae_ofs_sync));
    end
  end

endmodule

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo
  import afifo_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int ADDR_W  = 8,
  parameter int DEF_OFS = DEFAULT_OFFSET
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              wr_en1_n,
  input  logic              wr_en2_ld_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en1_n,
  input  logic              rd_en2_n,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              empty_n,
  output logic              almost_empty_n,
  output logic              full_n,
  output logic              almost_full_n
);

  localparam int PW = ADDR_W + 1;

  logic              mem_we, mem_re, ld_mode;
  logic [ADDR_W-1:0] waddr, raddr, ae_ofs_w, ae_ofs_r;
  logic [PW-1:0]     w_gray, r_gray, w_gray_s, r_gray_s;
  logic [DATA_W-1:0] q_word;

  afifo_wr_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEF_OFS(DEF_OFS)) u_wr (
    .clk(wr_clk), .rst(rst), .en1_n(wr_en1_n), .en2_ld_n(wr_en2_ld_n),
    .wdata(wr_data), .rgray_sync(r_gray_s), .mem_we(mem_we), .mem_waddr(waddr),
    .wgray(w_gray), .full_n(full_n), .af_n(almost_full_n), .ae_ofs(ae_ofs_w),
    .ld_mode(ld_mode)
  );

  afifo_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rst), .en1_n(rd_en1_n), .en2_n(rd_en2_n),
    .wgray_sync(w_gray_s), .ae_ofs_sync(ae_ofs_r), .mem_re(mem_re),
    .mem_raddr(raddr), .rgray(r_gray), .empty_n(empty_n), .ae_n(almost_empty_n)
  );

  afifo_sync #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .rst(rst), .d(w_gray), .q(w_gray_s)
  );

  afifo_sync #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .rst(rst), .d(r_gray), .q(r_gray_s)
  );

  // Almost-empty threshold changes only while idle, so a plain double flop suffices.
  afifo_sync #(.W(ADDR_W), .RST_VAL(ADDR_W'(DEF_OFS))) u_sync_ofs (
    .clk(rd_clk), .rst(rst), .d(ae_ofs_w), .q(ae_ofs_r)
  );

  afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .re(mem_re), .raddr(raddr), .rdata(q_word)
  );

  // Pad model: drive indicator plus zeroed data while released.
  assign rd_drive = !out_en_n;
  assign rd_data  = out_en_n ? '0 : q_word;

endmodule

// File: rtl/flagfifo_chk.sv
module flagfifo_chk #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst,
  input logic              wr_en1_n,
  input logic              wr_en2_ld_n,
  input logic              out_en_n,
  input logic              rd_drive,
  input logic [DATA_W-1:0] rd_data,
  input logic              empty_n,
  input logic              almost_empty_n,
  input logic              full_n,
  input logic              almost_full_n,
  input logic [ADDR_W:0]   w_gray,
  input logic [ADDR_W:0]   r_gray,
  input logic              ld_mode
);

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (rst) !full_n |=> $stable(w_gray)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rst) !empty_n |=> $stable(r_gray)); // R5
  AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (rst) $countones(w_gray ^ $past(w_gray)) <= 1); // R12
  AST_RGRAY_STEP: assert property (@(posedge rd_clk) disable iff (rst) $countones(r_gray ^ $past(r_gray)) <= 1); // R12
  AST_EMPTY_IS_LOW: assert property (@(posedge rd_clk) disable iff (rst) !empty_n |-> !almost_empty_n); // R8
  AST_FULL_IS_HIGH: assert property (@(posedge wr_clk) disable iff (rst) !full_n |-> !almost_full_n); // R8
  AST_RESET_WR_FLAGS: assert property (@(posedge wr_clk) rst |=> (full_n && almost_full_n)); // R9
  AST_RESET_RD_FLAGS: assert property (@(posedge rd_clk) rst |=> (!empty_n && !almost_empty_n)); // R9
  AST_LOAD_NO_WRITE: assert property (@(posedge wr_clk) disable iff (rst) (ld_mode && !wr_en1_n && !wr_en2_ld_n) |=> $stable(w_gray)); // R11
  AST_RELEASED: assert property (@(posedge rd_clk) disable iff (rst) out_en_n |-> (!rd_drive && rd_data == '0)); // R6

endmodule

bind dual_clock_flag_fifo flagfifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en1_n(wr_en1_n),
  .wr_en2_ld_n(wr_en2_ld_n), .out_en_n(out_en_n), .rd_drive(rd_drive),
  .rd_data(rd_data), .empty_n(empty_n), .almost_empty_n(almost_empty_n),
  .full_n(full_n), .almost_full_n(almost_full_n), .w_gray(w_gray),
  .r_gray(r_gray), .ld_mode(ld_mode)
);

// File: tb/test_dual_clock_flag_fifo.sv
module test_dual_clock_flag_fifo;

  localparam int DW    = 9;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0;
  logic clk_b = 1'b0;
  logic async_sel = 1'b0;
  logic rd_clk;
  always #10 wr_clk = ~wr_clk;
  always #17 clk_b = ~clk_b;
  assign rd_clk = async_sel ? clk_b : wr_clk;

  logic          rst = 1'b1;
  logic          wr_en1_n = 1'b1;
  logic          wr_en2_ld_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en1_n = 1'b1;
  logic          rd_en2_n = 1'b1;
  logic          out_en_n = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_drive, empty_n, almost_empty_n, full_n, almost_full_n;

  int vectors = 0;
  int miscompares = 0;
  int wr_seq = 0;
  int rd_seq = 0;
  bit ldm = 1'b0;
  bit done = 1'b0;

  dual_clock_flag_fifo #(.DATA_W(DW), .ADDR_W(AW)) i_dual_clock_flag_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en1_n(wr_en1_n),
    .wr_en2_ld_n(wr_en2_ld_n), .wr_data(wr_data), .rd_en1_n(rd_en1_n),
    .rd_en2_n(rd_en2_n), .out_en_n(out_en_n), .rd_data(rd_data),
    .rd_drive(rd_drive), .empty_n(empty_n), .almost_empty_n(almost_empty_n),
    .full_n(full_n), .almost_full_n(almost_full_n)
  );

  function automatic logic [DW-1:0] pat(int k);
    return DW'((k * 73 + 5) % 512);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge wr_clk);
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic check_flags(string req, int cnt, int ae, int af);
    check(req, "empty_n", int'(empty_n), (cnt == 0) ? 0 : 1);
    check(req, "full_n", int'(full_n), (cnt == DEPTH) ? 0 : 1);
    check(req, "almost_empty_n", int'(almost_empty_n), (cnt <= ae) ? 0 : 1);
    check(req, "almost_full_n", int'(almost_full_n), (cnt >= DEPTH - af) ? 0 : 1);
  endtask

  task automatic do_reset(bit lm, bit as);
    @(negedge wr_clk);
    rst = 1'b1;
    wr_en1_n = 1'b1;
    wr_en2_ld_n = lm ? 1'b0 : 1'b1;
    rd_en1_n = 1'b1;
    rd_en2_n = 1'b1;
    async_sel = as;
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge clk_b);
    @(negedge wr_clk);
    rst = 1'b0;
    wr_en2_ld_n = 1'b1;
    ldm = lm;
    wr_seq = 0;
    rd_seq = 0;
    settle();
  endtask

  // Data write in the active mode; returns at the negedge after the edge.
  task automatic wr_one(logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_data = d;
    wr_en1_n = 1'b0;
    wr_en2_ld_n = ldm ? 1'b1 : 1'b0;
    @(negedge wr_clk);
    wr_en1_n = 1'b1;
    wr_en2_ld_n = 1'b1;
  endtask

  task automatic rd_one();
    @(negedge rd_clk);
    rd_en1_n = 1'b0;
    rd_en2_n = 1'b0;
    @(negedge rd_clk);
    rd_en1_n = 1'b1;
    rd_en2_n = 1'b1;
  endtask

  // Load mode: almost-empty threshold first, then almost-full (R11).
  task automatic load_ofs(int ae, int af);
    @(negedge wr_clk);
    wr_en1_n = 1'b0;
    wr_en2_ld_n = 1'b0;
    wr_data = DW'(ae);
    @(negedge wr_clk);
    wr_data = DW'(af);
    @(negedge wr_clk);
    wr_en1_n = 1'b1;
    wr_en2_ld_n = 1'b1;
  endtask

  task automatic fill_drain(int ae, int af, string dtag);
    int cnt = 0;
    logic [DW-1:0] hold;
    for (int i = 0; i < DEPTH; i++) begin
      wr_one(pat(wr_seq));
      wr_seq++;
      cnt++;
      check("R7", "full_n same edge", int'(full_n), (cnt == DEPTH) ? 0 : 1);
      settle();
      check_flags("R8", cnt, ae, af);
    end
    wr_one(pat(999));
    settle();
    check("R4", "full_n after extra write", int'(full_n), 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd_one();
      check(dtag, "rd_data order", int'(rd_data), int'(pat(rd_seq)));
      rd_seq++;
      cnt--;
      check("R7", "empty_n same edge", int'(empty_n), (cnt == 0) ? 0 : 1);
      settle();
      check_flags("R7", cnt, ae, af);
    end
    hold = rd_data;
    rd_one();
    settle();
    check("R5", "rd_data on empty read", int'(rd_data), int'(hold));
    check("R4", "no extra word stored", int'(empty_n), 0);
  endtask

  initial begin
    int pairs_ae[4] = '{0, 2, 15, 5};
    int pairs_af[4] = '{0, 3, 15, 11};
    logic [DW-1:0] hold;

    // R9: reset values in enable mode
    do_reset(1'b0, 1'b0);
    check_flags("R9", 0, 7, 7);
    check("R6", "rd_drive when enabled", int'(rd_drive), 1);

    // R1 R8 with default thresholds of 7
    fill_drain(7, 7, "R1");

    // R3: one write qualifier only
    @(negedge wr_clk);
    wr_data = 9'h1AA;
    wr_en1_n = 1'b0;
    wr_en2_ld_n = 1'b1;
    @(negedge wr_clk);
    wr_en1_n = 1'b1;
    wr_en2_ld_n = 1'b0;
    @(negedge wr_clk);
    wr_en2_ld_n = 1'b1;
    settle();
    check("R3", "empty_n after half writes", int'(empty_n), 0);

    // R2: one read qualifier only
    wr_one(pat(wr_seq));
    wr_seq++;
    settle();
    hold = rd_data;
    @(negedge rd_clk);
    rd_en1_n = 1'b0;
    @(negedge rd_clk);
    rd_en1_n = 1'b1;
    rd_en2_n = 1'b0;
    @(negedge rd_clk);
    rd_en2_n = 1'b1;
    settle();
    check("R2", "rd_data after half reads", int'(rd_data), int'(hold));
    check("R2", "empty_n after half reads", int'(empty_n), 1);
    rd_one();
    check("R2", "word kept for real read", int'(rd_data), int'(pat(rd_seq)));
    rd_seq++;

    // R6: output release
    @(negedge rd_clk);
    out_en_n = 1'b1;
    #1;
    check("R6", "rd_drive released", int'(rd_drive), 0);
    check("R6", "rd_data released", int'(rd_data), 0);
    out_en_n = 1'b0;
    #1;
    check("R6", "rd_drive driven", int'(rd_drive), 1);
    check("R6", "rd_data restored", int'(rd_data), int'(pat(rd_seq - 1)));

    // R10 R11: load mode sweeps over threshold pairs
    for (int p = 0; p < 4; p++) begin
      do_reset(1'b1, 1'b0);
      check_flags("R9", 0, 7, 7);
      load_ofs(pairs_ae[p], pairs_af[p]);
      settle();
      check_flags("R11", 0, pairs_ae[p], pairs_af[p]);
      fill_drain(pairs_ae[p], pairs_af[p], "R10 R11");
    end

    // R13 with R12 crossing: asynchronous read clock
    do_reset(1'b0, 1'b1);
    check_flags("R9", 0, 7, 7);
    fill_drain(7, 7, "R12 R13");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule